// File: doc/BRIEF.md
# ADC Test Pattern Generator

This block supplies the sample stream that a digitizer channel's processing chain would normally receive from its converter. On every clock it delivers one 16-bit sample and a valid flag. A mode select picks the source: the real converter sample passed straight through, or one of six built-in test patterns. The patterns are an alternating bit pattern, a full-width ramp, an eight-point sine, a pseudo-random word stream, a ramp tagged with the channel number, and a square wave with programmable timing and levels. The test patterns let the downstream filters, triggers and readout be checked with known data and no analog signal.

The output is registered, so the sample follows its inputs by one clock. Each pattern starts over from its first element after reset and whenever the mode select changes. A pattern can therefore be lined up with the moment it was selected.

Top module: `adc_pat_gen`

## Requirements
- R1: While `rst` is high, `sample_o` is 0 and `valid_o` is 0. At the first rising edge with `rst` low, `valid_o` becomes 1 and stays 1, and `sample_o` shows element 0 of the selected pattern.
- R2: In mode 0 (converter), and in the reserved mode 7, `sample_o` after an edge equals the `adc_i` value sampled at that edge.
- R3: Mode 1 (alternating) outputs 0x5555 as element 0, then 0xAAAA, and keeps alternating on every clock.
- R4: Mode 2 (ramp) outputs element k as k modulo 65536, so it wraps from 0xFFFF to 0x0000.
- R5: Mode 3 (sine) repeats this eight-value sequence around mid-scale: 0x8000, 0xDA82, 0xFFFF, 0xDA82, 0x8000, 0x257E, 0x0001, 0x257E.
- R6: Mode 4 (PRBS) uses a 23-bit register seeded with 0x2A5A5A. Each shift moves the register left and inserts the XOR of bits 22 and 17 at bit 0. Element k is bits [15:0] of the register after 16·(k+1) shifts from the seed.
- R7: Mode 5 (channel ramp) outputs `chan_i` in bits [15:10] and k modulo 1024 in bits [9:0]. For channel 1 the values therefore run from 1024 to 2047.
- R8: Mode 6 (square) with 0 < `sq_width_i` < `sq_period_i` outputs `sq_high_i` when k modulo `sq_period_i` is less than `sq_width_i`, and `sq_low_i` otherwise.
- R9: In mode 6, a width of 0 holds the output at `sq_low_i`. A nonzero width not smaller than the period holds the output at `sq_high_i`.
- R10: When `mode_i` differs from its value at the previous edge, the new pattern restarts at element 0, whatever state it was left in earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 3 | Source select (0 converter, 1 alternating, 2 ramp, 3 sine, 4 PRBS, 5 channel ramp, 6 square, 7 reserved) |
| chan_i | input | 6 | Channel number used by the channel ramp |
| adc_i | input | 16 | Converter sample |
| sq_period_i | input | 16 | Square-wave period in clocks |
| sq_width_i | input | 16 | Square-wave high time in clocks |
| sq_low_i | input | 16 | Square-wave low level |
| sq_high_i | input | 16 | Square-wave high level |
| sample_o | output | 16 | Generated sample |
| valid_o | output | 1 | Sample valid |

## Verification
Each mode is run over long enough stretches to show its full behaviour:

- The ramp runs through a complete 16-bit wrap.
- The channel ramp runs past its 10-bit rollover for two different channel numbers. This shows that the tag bits and the count bits stay separate.
- The PRBS is compared word by word against an arithmetic model of the shift register for several hundred words.
- Random converter data is used for pass-through, which separates a true copy from any pattern.
- The square wave is tried with an ordinary duty cycle and with a period that does not divide evenly. It is also tried with a zero width, a width equal to the period and a width above the period, which tells the two saturation rules apart.
- Switching away from a mode and back again shows that the pattern restarts rather than resumes.

// File: rtl/adc_pat_pkg.sv
package adc_pat_pkg;

    localparam int SMP_W = 16;

    typedef enum logic [2:0] {
        SRC_ADC    = 3'd0,
        SRC_ALT    = 3'd1,
        SRC_RAMP   = 3'd2,
        SRC_SINE   = 3'd3,
        SRC_PRBS   = 3'd4,
        SRC_CHRAMP = 3'd5,
        SRC_SQUARE = 3'd6,
        SRC_RSVD   = 3'd7
    } src_e;

    localparam logic [SMP_W-1:0] ALT_EVEN = 16'h5555;
    localparam logic [SMP_W-1:0] ALT_ODD  = 16'hAAAA;

    // mid-scale and the two sine magnitudes (full and 1/sqrt2)
    localparam logic [SMP_W-1:0] SIN_MID  = 16'h8000;
    localparam logic [SMP_W-1:0] SIN_FULL = 16'h7FFF;
    localparam logic [SMP_W-1:0] SIN_DIAG = 16'h5A82;

    function automatic logic [SMP_W-1:0] sine_point(input logic [2:0] idx);
        logic [SMP_W-1:0] mag;
        case (idx[1:0])
            2'd0:    mag = '0;
            2'd2:    mag = SIN_FULL;
            default: mag = SIN_DIAG;
        endcase
        if (idx[2]) return SIN_MID - mag;
        else        return SIN_MID + mag;
    endfunction

endpackage

// File: rtl/adc_pat_prbs.sv
module adc_pat_prbs #(
    parameter int LFSR_W = 23,
    parameter int TAP    = 18,
    parameter int STEP   = 16,
    parameter logic [LFSR_W-1:0] SEED = 23'h2A5A5A
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart_i,
    output logic [STEP-1:0] word_o
);

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
    } prbs_st_t;

    prbs_st_t st_d, st_q;

    function automatic logic [LFSR_W-1:0] advance(input logic [LFSR_W-1:0] s_in);
        logic [LFSR_W-1:0] s;
        logic fb;
        s = s_in;
        for (int i = 0; i < STEP; i++) begin
            fb = s[LFSR_W-1] ^ s[TAP-1];
            s  = {s[LFSR_W-2:0], fb};
        end
        return s;
    endfunction

    always_comb begin
        logic [LFSR_W-1:0] base;
        base    = restart_i ? SEED : st_q.lfsr;
        st_d    = st_q;
        st_d.lfsr = advance(base);
        word_o  = st_d.lfsr[STEP-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.lfsr <= SEED;
        else     st_q <= st_d;
    end

    // R6
    prbs_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.lfsr != '0);

endmodule

// File: rtl/adc_pat_square.sv
module adc_pat_square #(
    parameter int CNT_W = 16,
    parameter int LVL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] width_i,
    input  logic [LVL_W-1:0] low_i,
    input  logic [LVL_W-1:0] high_i,
    output logic [LVL_W-1:0] word_o
);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
    } sq_st_t;

    sq_st_t st_d, st_q;

    always_comb begin
        logic [CNT_W-1:0] pos;
        logic [CNT_W:0]   inc;
        logic             hi;
        pos  = restart_i ? '0 : st_q.pos;
        hi   = (width_i != '0) && ((width_i >= period_i) || (pos < width_i));
        word_o = hi ? high_i : low_i;
        inc  = {1'b0, pos} + 1'b1;
        st_d = st_q;
        st_d.pos = (inc >= {1'b0, period_i}) ? '0 : inc[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.pos <= '0;
        else     st_q <= st_d;
    end

    // R8
    sq_pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (period_i == $past(period_i) && period_i != '0) |-> st_q.pos < period_i);

endmodule

// File: rtl/adc_pat_gen.sv
module adc_pat_gen
    import adc_pat_pkg::*;
#(
    parameter int CH_W  = 6,
    parameter int SQ_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic [SMP_W-1:0] adc_i,
    input  logic [SQ_W-1:0]  sq_period_i,
    input  logic [SQ_W-1:0]  sq_width_i,
    input  logic [SMP_W-1:0] sq_low_i,
    input  logic [SMP_W-1:0] sq_high_i,
    output logic [SMP_W-1:0] sample_o,
    output logic             valid_o
);

    localparam int CNT_LO_W = SMP_W - CH_W;

    typedef struct packed {
        logic [SMP_W-1:0] sample;
        logic             valid;
        logic             first;
        src_e             mode;
        logic [SMP_W-1:0] step;
    } gen_st_t;

    gen_st_t st_d, st_q;

    logic             restart;
    logic [SMP_W-1:0] prbs_word;
    logic [SMP_W-1:0] sq_word;

    assign restart = st_q.first || (mode_i != st_q.mode);

    adc_pat_prbs #(
        .LFSR_W (23),
        .TAP    (18),
        .STEP   (SMP_W),
        .SEED   (23'h2A5A5A)
    ) u_prbs (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .word_o    (prbs_word)
    );

    adc_pat_square #(
        .CNT_W (SQ_W),
        .LVL_W (SMP_W)
    ) u_square (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .period_i  (sq_period_i),
        .width_i   (sq_width_i),
        .low_i     (sq_low_i),
        .high_i    (sq_high_i),
        .word_o    (sq_word)
    );

    always_comb begin
        logic [SMP_W-1:0] k;
        k    = restart ? '0 : st_q.step;
        st_d = st_q;
        st_d.step  = k + 1'b1;
        st_d.mode  = src_e'(mode_i);
        st_d.first = 1'b0;
        st_d.valid = 1'b1;
        case (src_e'(mode_i))
            SRC_ALT:    st_d.sample = k[0] ? ALT_ODD : ALT_EVEN;
            SRC_RAMP:   st_d.sample = k;
            SRC_SINE:   st_d.sample = sine_point(k[2:0]);
            SRC_PRBS:   st_d.sample = prbs_word;
            SRC_CHRAMP: st_d.sample = {chan_i, k[CNT_LO_W-1:0]};
            SRC_SQUARE: st_d.sample = sq_word;
            default:    st_d.sample = adc_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sample <= '0;
            st_q.valid  <= 1'b0;
            st_q.first  <= 1'b1;
            st_q.mode   <= SRC_ADC;
            st_q.step   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_o = st_q.sample;
    assign valid_o  = st_q.valid;

    // R1
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> valid_o);

    // R2
    pass_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == SRC_ADC) |=> sample_o == $past(adc_i));

    // R3
    alt_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == SRC_ALT && st_q.mode == SRC_ALT && valid_o)
        |=> sample_o == ~$past(sample_o));

    // R4
    ramp_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == SRC_RAMP && st_q.mode == SRC_RAMP && valid_o)
        |=> sample_o == $past(sample_o) + 1'b1);

    // R7
    chramp_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == SRC_CHRAMP) |=> sample_o[SMP_W-1:CNT_LO_W] == $past(chan_i));

    // R9
    sq_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == SRC_SQUARE && sq_width_i == '0) |=> sample_o == $past(sq_low_i));

endmodule

// File: tb/sim_adc_pat_gen.sv
module sim_adc_pat_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode = 3'd1;
    logic [5:0]  chan = 6'd0;
    logic [15:0] adc = 16'd0;
    logic [15:0] per = 16'd5, wid = 16'd2, lo = 16'h0100, hi = 16'hF000;
    logic [15:0] sample;
    logic        valid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    adc_pat_gen u0 (
        .clk(clk), .rst(rst), .mode_i(mode), .chan_i(chan), .adc_i(adc),
        .sq_period_i(per), .sq_width_i(wid), .sq_low_i(lo), .sq_high_i(hi),
        .sample_o(sample), .valid_o(valid)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sine_ref(input int k);
        logic [15:0] t [8] = '{16'h8000, 16'hDA82, 16'hFFFF, 16'hDA82,
                               16'h8000, 16'h257E, 16'h0001, 16'h257E};
        return t[k % 8];
    endfunction

    // mode m for n clocks, element k checked after the k-th edge
    task automatic play(input logic [2:0] m, input int n, input string req);
        logic [22:0] lf;
        logic [15:0] drv, exp;
        int p;
        lf = 23'h2A5A5A;
        @(negedge clk);
        mode = m;
        for (int k = 0; k < n; k++) begin
            adc = 16'($urandom);
            drv = adc;
            @(posedge clk);
            #1;
            case (m)
                3'd1: exp = (k % 2) ? 16'hAAAA : 16'h5555;
                3'd2: exp = 16'(k);
                3'd3: exp = sine_ref(k);
                3'd4: begin
                    for (int s = 0; s < 16; s++) lf = {lf[21:0], lf[22] ^ lf[17]};
                    exp = lf[15:0];
                end
                3'd5: exp = {chan, 10'(k % 1024)};
                3'd6: begin
                    p = (per == 0) ? 0 : k % per;
                    if (wid == 0)        exp = lo;
                    else if (wid >= per) exp = hi;
                    else                 exp = (p < wid) ? hi : lo;
                end
                default: exp = drv;
            endcase
            chk(sample, exp, req);
            chk({15'd0, valid}, 16'd1, "R1");
            @(negedge clk);
        end
    endtask

    initial begin
        #1_500_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #1;
            chk(sample, 16'd0, "R1");
            chk({15'd0, valid}, 16'd0, "R1");
        end
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk({15'd0, valid}, 16'd1, "R1");
        chk(sample, 16'h5555, "R1");

        play(3'd2, 65540, "R4");
        play(3'd1, 9, "R3");
        play(3'd3, 17, "R5");
        play(3'd4, 300, "R6");
        chan = 6'd1;
        play(3'd5, 1030, "R7");
        play(3'd0, 20, "R2");
        chan = 6'd63;
        play(3'd5, 1030, "R7");
        play(3'd7, 10, "R2");
        per = 16'd5; wid = 16'd2;
        play(3'd6, 15, "R8");
        play(3'd1, 1, "R3");
        per = 16'd7; wid = 16'd3;
        play(3'd6, 22, "R8");
        play(3'd1, 1, "R3");
        per = 16'd4; wid = 16'd0;
        play(3'd6, 10, "R9");
        play(3'd1, 1, "R3");
        per = 16'd3; wid = 16'd3;
        play(3'd6, 8, "R9");
        play(3'd1, 1, "R3");
        per = 16'd3; wid = 16'd9;
        play(3'd6, 8, "R9");

        // R10 restart after leaving a mode and returning
        play(3'd2, 10, "R10");
        play(3'd1, 3, "R10");
        play(3'd2, 5, "R10");
        play(3'd4, 5, "R10");
        play(3'd3, 2, "R10");
        play(3'd4, 5, "R10");
        play(3'd5, 7, "R10");
        play(3'd0, 2, "R10");
        play(3'd5, 4, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule